// File: doc/BRIEF.md
# Output Amplitude Keying Controller

This block produces the amplitude word that scales a synthesizer's output. It decodes a 32-bit control word into three fields: a ramp period, a target amplitude and a step-size code. While enabled, it also raises a flag that tells the downstream amplitude path to take this word in place of every other amplitude source.

There are two modes. In manual mode the target amplitude goes straight to the output. An external keying pin can optionally gate it to zero. In automatic mode an internal amplitude register steps toward the target while the keying pin is high, and toward zero while it is low. It takes one step each time a period timer expires. The step saturates at both ends. The period is captured from the control word on an update strobe. When the block is disabled, all of its state freezes and it claims no control of the amplitude path.

Top module: `amp_key_ctrl`

## Requirements
- R1: The control word holds the ramp period in bits [31:16], the target amplitude in bits [15:2] and the step-size code in bits [1:0].
- R2: With `osk_en` low, `amp_valid` is 0 and `amp_out` is 0. The keying inputs have no effect, and the ramp amplitude and period timer keep their values until the block is enabled again.
- R3: With `osk_en` high, `amp_valid` is 1. `auto_sel` = 0 selects manual mode and `auto_sel` = 1 selects automatic mode.
- R4: In manual mode with `man_ext` = 0, `amp_out` equals the target field in the same cycle, and `key_pin` is ignored.
- R5: In manual mode with `man_ext` = 1, `key_pin` = 0 forces `amp_out` to 0 and `key_pin` = 1 passes the target field.
- R6: A clock edge with `io_update` high captures the period field and restarts the timer. While in automatic mode, the first step falls P edges after that edge, and later steps every P edges, where P is the period field, or 1 when the field is 0.
- R7: Step-size codes 0, 1, 2 and 3 give steps of 1, 2, 4 and 8 LSBs.
- R8: In automatic mode with `key_pin` = 1, each step raises the amplitude by the step size, saturating at the target. `amp_out` shows the ramp amplitude.
- R9: In automatic mode with `key_pin` = 0, each step lowers the amplitude by the step size, saturating at 0.
- R10: When `io_update` falls on an edge where a step is due, the step is still taken, and the new period counts from that edge.
- R11: A synchronous reset clears the ramp amplitude, the captured period and the timer. After reset the automatic mode therefore steps on every edge until a period is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 32 | Period, target amplitude and step code |
| osk_en | input | 1 | Block enable |
| auto_sel | input | 1 | 0 = manual, 1 = automatic ramp |
| man_ext | input | 1 | In manual mode, lets the keying pin gate the output |
| key_pin | input | 1 | External keying input |
| io_update | input | 1 | Captures the period field and restarts the timer |
| amp_out | output | 14 | Amplitude word |
| amp_valid | output | 1 | Override flag for the amplitude path |

## Verification
Two events can fall on the same edge: a period reload from `io_update` and a ramp step from the expiring timer. The bench first loads a period of 5 and lets the ramp run. It then raises `io_update` with a new period of 2 on exactly the fifth edge after the load. The judgement is that the amplitude still moves up by one step on that edge, that the next step comes two edges later rather than five, and that the values land at 4, 8 and 12 on the predicted cycles.

// File: rtl/amp_key_pkg.sv
package amp_key_pkg;

   // Operating mode decoded from the enable and select bits
   typedef enum logic [1:0] {
      AK_OFF    = 2'd0,
      AK_MANUAL = 2'd1,
      AK_AUTO   = 2'd2
   } amp_mode_e;

endpackage

// File: rtl/amp_key_rate_timer.sv
// Period timer: emits one tick every max(period,1) edges while running.
module amp_key_rate_timer #(
   parameter int RATE_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              load,
   input  logic [RATE_W-1:0] rate_in,
   output logic              tick
);

   logic [RATE_W-1:0] rate_q;
   logic [RATE_W-1:0] cnt_q;
   logic [RATE_W-1:0] eff_new;
   logic [RATE_W-1:0] eff_cur;

   assign eff_new = (rate_in == '0) ? RATE_W'(1) : rate_in;
   assign eff_cur = (rate_q == '0) ? RATE_W'(1) : rate_q;
   assign tick    = run && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         rate_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (load) rate_q <= rate_in;
         if (run) begin
            if (load)               cnt_q <= eff_new - RATE_W'(1);
            else if (cnt_q == '0)   cnt_q <= eff_cur - RATE_W'(1);
            else                    cnt_q <= cnt_q - RATE_W'(1);
         end
      end
   end

endmodule

// File: rtl/amp_key_ramp.sv
// Saturating amplitude ramp register.
module amp_key_ramp #(
   parameter int AMP_W    = 14,
   parameter int STEP_W   = 2,
   parameter bit STEP_EXP = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              advance,
   input  logic              up,
   input  logic [AMP_W-1:0]  target,
   input  logic [STEP_W-1:0] step_code,
   output logic [AMP_W-1:0]  amp_q
);

   localparam int SW = AMP_W + 1;

   logic [SW-1:0]    step;
   logic [SW-1:0]    sum;
   logic [AMP_W-1:0] nxt;

   generate
      if (STEP_EXP) begin : g_step_pow2
         assign step = SW'(1) << step_code;
      end else begin : g_step_linear
         assign step = SW'(step_code) + SW'(1);
      end
   endgenerate

   assign sum = {1'b0, amp_q} + step;

   always_comb begin
      if (up) begin
         nxt = (sum >= {1'b0, target}) ? target : sum[AMP_W-1:0];
      end else begin
         nxt = ({1'b0, amp_q} <= step) ? '0 : (amp_q - step[AMP_W-1:0]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          amp_q <= '0;
      else if (advance) amp_q <= nxt;
   end

endmodule

// File: rtl/amp_key_ctrl.sv
module amp_key_ctrl
   import amp_key_pkg::*;
#(
   parameter int AMP_W    = 14,
   parameter int RATE_W   = 16,
   parameter int STEP_W   = 2,
   parameter bit STEP_EXP = 1'b1,
   parameter bit OUT_REG  = 1'b0,
   localparam int CTRL_W  = RATE_W + AMP_W + STEP_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              osk_en,
   input  logic              auto_sel,
   input  logic              man_ext,
   input  logic              key_pin,
   input  logic              io_update,
   output logic [AMP_W-1:0]  amp_out,
   output logic              amp_valid
);

   localparam int AMP_LSB  = STEP_W;
   localparam int RATE_LSB = STEP_W + AMP_W;

   generate
      if (AMP_W < 4)    begin : g_bad_amp  $error("AMP_W must be at least 4");  end
      if (STEP_W < 1)   begin : g_bad_step $error("STEP_W must be at least 1"); end
      if (RATE_W < 2)   begin : g_bad_rate $error("RATE_W must be at least 2"); end
      if (STEP_EXP && ((1 << STEP_W) > AMP_W)) begin : g_bad_exp
         $error("largest power-of-two step does not fit AMP_W");
      end
   endgenerate

   logic [STEP_W-1:0] step_code;
   logic [AMP_W-1:0]  scale;
   logic [RATE_W-1:0] rate_fld;
   amp_mode_e         mode;
   logic              ramp_run;
   logic              tick;
   logic [AMP_W-1:0]  ramp_amp;
   logic [AMP_W-1:0]  amp_sel;
   logic              valid_sel;

   assign step_code = ctrl_word[AMP_LSB-1:0];
   assign scale     = ctrl_word[RATE_LSB-1:AMP_LSB];
   assign rate_fld  = ctrl_word[CTRL_W-1:RATE_LSB];

   always_comb begin
      if (!osk_en)       mode = AK_OFF;
      else if (auto_sel) mode = AK_AUTO;
      else               mode = AK_MANUAL;
   end

   assign ramp_run = (mode == AK_AUTO);

   amp_key_rate_timer #(.RATE_W(RATE_W)) timer_i (
      .clk     (clk),
      .rst     (rst),
      .run     (ramp_run),
      .load    (io_update),
      .rate_in (rate_fld),
      .tick    (tick)
   );

   amp_key_ramp #(.AMP_W(AMP_W), .STEP_W(STEP_W), .STEP_EXP(STEP_EXP)) ramp_i (
      .clk       (clk),
      .rst       (rst),
      .advance   (tick),
      .up        (key_pin),
      .target    (scale),
      .step_code (step_code),
      .amp_q     (ramp_amp)
   );

   always_comb begin
      case (mode)
         AK_MANUAL: begin
            amp_sel   = (man_ext && !key_pin) ? '0 : scale;
            valid_sel = 1'b1;
         end
         AK_AUTO: begin
            amp_sel   = ramp_amp;
            valid_sel = 1'b1;
         end
         default: begin
            amp_sel   = '0;
            valid_sel = 1'b0;
         end
      endcase
   end

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               amp_out   <= '0;
               amp_valid <= 1'b0;
            end else begin
               amp_out   <= amp_sel;
               amp_valid <= valid_sel;
            end
         end
      end else begin : g_out_comb
         assign amp_out   = amp_sel;
         assign amp_valid = valid_sel;
      end
   endgenerate

endmodule

// File: rtl/amp_key_ctrl_chk.sv
module amp_key_ctrl_chk #(
   parameter int AMP_W   = 14,
   parameter int CTRL_W  = 32,
   parameter int STEP_W  = 2,
   parameter bit OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic              osk_en,
   input logic              auto_sel,
   input logic              man_ext,
   input logic              key_pin,
   input logic [AMP_W-1:0]  amp_out,
   input logic              amp_valid,
   input logic [AMP_W-1:0]  amp_q
);

   logic [AMP_W-1:0] tgt;
   logic             comb_out;
   assign tgt      = ctrl_word[STEP_W+AMP_W-1:STEP_W];
   assign comb_out = (OUT_REG == 1'b0);

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
      (comb_out && !osk_en) |-> (!amp_valid && amp_out == '0)); // R2
   AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !osk_en |=> $stable(amp_q)); // R2
   AST_EN_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
      (comb_out && osk_en) |-> amp_valid); // R3
   AST_MAN_PASS: assert property (@(posedge clk) disable iff (rst)
      (comb_out && osk_en && !auto_sel && (!man_ext || key_pin)) |-> (amp_out == tgt)); // R4
   AST_MAN_GATE: assert property (@(posedge clk) disable iff (rst)
      (comb_out && osk_en && !auto_sel && man_ext && !key_pin) |-> (amp_out == '0)); // R5
   AST_UP_CEIL: assert property (@(posedge clk) disable iff (rst)
      (osk_en && auto_sel && key_pin && amp_q <= tgt) |=> (amp_q <= $past(tgt))); // R8
   AST_DOWN_MONO: assert property (@(posedge clk) disable iff (rst)
      (osk_en && auto_sel && !key_pin) |=> (amp_q <= $past(amp_q))); // R9
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (amp_q == '0)); // R11

endmodule

bind amp_key_ctrl amp_key_ctrl_chk #(
   .AMP_W(AMP_W), .CTRL_W(CTRL_W), .STEP_W(STEP_W), .OUT_REG(OUT_REG)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .ctrl_word (ctrl_word),
   .osk_en    (osk_en),
   .auto_sel  (auto_sel),
   .man_ext   (man_ext),
   .key_pin   (key_pin),
   .amp_out   (amp_out),
   .amp_valid (amp_valid),
   .amp_q     (ramp_amp)
);

// File: tb/amp_key_ctrl_tb_top.sv
`timescale 1ns/100ps
module amp_key_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] ctrl_word = '0;
   logic        osk_en = 1'b0;
   logic        auto_sel = 1'b0;
   logic        man_ext = 1'b0;
   logic        key_pin = 1'b0;
   logic        io_update = 1'b0;
   logic [13:0] amp_out;
   logic        amp_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   amp_key_ctrl dut_i (
      .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .osk_en(osk_en),
      .auto_sel(auto_sel), .man_ext(man_ext), .key_pin(key_pin),
      .io_update(io_update), .amp_out(amp_out), .amp_valid(amp_valid)
   );

   typedef struct packed {
      logic        en;
      logic        au;
      logic        mx;
      logic        key;
      logic [13:0] tgt;
      logic        exp_v;
      logic [13:0] exp_a;
   } vec_t;

   localparam vec_t TABLE [10] = '{
      '{1'b1, 1'b0, 1'b0, 1'b0, 14'd100,   1'b1, 14'd100},
      '{1'b1, 1'b0, 1'b0, 1'b1, 14'd100,   1'b1, 14'd100},
      '{1'b1, 1'b0, 1'b1, 1'b0, 14'd100,   1'b1, 14'd0},
      '{1'b1, 1'b0, 1'b1, 1'b1, 14'd100,   1'b1, 14'd100},
      '{1'b1, 1'b0, 1'b1, 1'b1, 14'd16383, 1'b1, 14'd16383},
      '{1'b1, 1'b0, 1'b1, 1'b0, 14'd16383, 1'b1, 14'd0},
      '{1'b1, 1'b0, 1'b0, 1'b0, 14'd0,     1'b1, 14'd0},
      '{1'b1, 1'b0, 1'b0, 1'b1, 14'd8191,  1'b1, 14'd8191},
      '{1'b0, 1'b0, 1'b1, 1'b1, 14'd100,   1'b0, 14'd0},
      '{1'b0, 1'b1, 1'b0, 1'b1, 14'd100,   1'b0, 14'd0}
   };

   function automatic logic [31:0] mk_word(int rate, int tgt, int code);
      return {16'(rate), 14'(tgt), 2'(code)};
   endfunction

   task automatic check_val(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; osk_en = 1'b0; auto_sel = 1'b0; man_ext = 1'b0;
      key_pin = 1'b0; io_update = 1'b0; ctrl_word = '0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // Loads a period on edge A with the key low, then ramps up with the key high.
   task automatic ramp_up(int rate, int tgt, int code, int n, string tag);
      int per;
      int stp;
      per = (rate == 0) ? 1 : rate;
      stp = 1 << code;
      do_reset();
      ctrl_word = mk_word(rate, tgt, code);
      osk_en = 1'b1; auto_sel = 1'b1; key_pin = 1'b0; io_update = 1'b1;
      @(posedge clk);
      @(negedge clk);
      io_update = 1'b0; key_pin = 1'b1;
      for (int k = 1; k <= n; k++) begin
         int e;
         @(posedge clk);
         #1;
         e = (k / per) * stp;
         if (e > tgt) e = tgt;
         check_val(tag, int'(amp_out), e);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R11 reset state, R3 override flag in auto mode
      do_reset();
      osk_en = 1'b1; auto_sel = 1'b1;
      #1;
      check_val("R11 amp after reset", int'(amp_out), 0);
      check_val("R3 valid when enabled", int'(amp_valid), 1);

      // Manual and disabled table (R2 R3 R4 R5)
      do_reset();
      foreach (TABLE[i]) begin
         @(negedge clk);
         osk_en = TABLE[i].en; auto_sel = TABLE[i].au;
         man_ext = TABLE[i].mx; key_pin = TABLE[i].key;
         ctrl_word = mk_word(7, int'(TABLE[i].tgt), 1);
         #1;
         check_val("R4 R5 table amp", int'(amp_out), int'(TABLE[i].exp_a));
         check_val("R2 R3 table valid", int'(amp_valid), int'(TABLE[i].exp_v));
      end

      // R1 R6 R7 R8: period 3, step 4, target 18
      ramp_up(3, 18, 2, 18, "R8 ramp up period 3 step 4");
      // R9: ramp down
      for (int k = 19; k <= 24; k++) begin
         int e;
         @(negedge clk);
         key_pin = 1'b0;
         @(posedge clk);
         #1;
         e = 18 - ((k - 18) / 3) * 4;
         if (e < 0) e = 0;
         check_val("R9 ramp down", int'(amp_out), e);
      end
      // R2: disabled, key toggled, state frozen
      @(negedge clk);
      osk_en = 1'b0;
      for (int j = 1; j <= 9; j++) begin
         @(negedge clk);
         key_pin = j[0];
         @(posedge clk);
         #1;
         check_val("R2 amp while disabled", int'(amp_out), 0);
         check_val("R2 valid while disabled", int'(amp_valid), 0);
      end
      @(negedge clk);
      osk_en = 1'b1; key_pin = 1'b0;
      #1;
      check_val("R2 amp held over disable", int'(amp_out), 10);
      for (int j = 1; j <= 9; j++) begin
         int e;
         @(posedge clk);
         #1;
         e = 10 - (j / 3) * 4;
         if (e < 0) e = 0;
         check_val("R2 R9 timer frozen then floor at zero", int'(amp_out), e);
      end

      // R6 R7: period 0 as 1, step 2, target 5
      ramp_up(0, 5, 1, 4, "R6 R7 period zero step 2");
      // R7: step 8, period 1
      ramp_up(1, 30, 3, 5, "R7 step 8 saturate");
      // R7: step 1, period 2
      ramp_up(2, 3, 0, 8, "R7 step 1 period 2");
      // R1: upper period bits, period 256
      ramp_up(256, 40, 0, 600, "R1 R6 period 256");

      // R10: update coinciding with a step
      do_reset();
      ctrl_word = mk_word(5, 40, 2);
      osk_en = 1'b1; auto_sel = 1'b1; key_pin = 1'b0; io_update = 1'b1;
      @(posedge clk);
      @(negedge clk);
      io_update = 1'b0; key_pin = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         @(posedge clk);
         #1;
         check_val("R10 before step", int'(amp_out), 0);
      end
      @(negedge clk);
      io_update = 1'b1; ctrl_word = mk_word(2, 40, 2);
      @(posedge clk);
      #1;
      check_val("R10 step kept on update edge", int'(amp_out), 4);
      @(negedge clk);
      io_update = 1'b0;
      for (int k = 6; k <= 9; k++) begin
         @(posedge clk);
         #1;
         check_val("R10 new period from update edge", int'(amp_out), ((k - 5) / 2) * 4 + 4);
      end

      // R11: reset mid-ramp clears amplitude and period
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check_val("R11 amp cleared by reset", int'(amp_out), 0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      check_val("R11 period cleared, step each edge", int'(amp_out), 4);
      @(posedge clk);
      #1;
      check_val("R11 period cleared, second edge", int'(amp_out), 8);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule